// File: doc/BRIEF.md
# Dual-Channel ROM Sample Playback Engine

This block plays two independent streams of 8-bit waveform samples, channel A and channel B, out of a shared ROM address space. Each channel owns a small byte-writable register set: a control byte, a volume byte, a 19-bit first-sample address, a 19-bit last-sample address and a 16-bit rate word. Once started, a channel walks its address window one byte per sample tick. It either wraps back to the first address or stops and holds its final level. Each new byte lands in that channel's output level register. When the scale bit is set, the byte is multiplied by the volume byte first.

Each channel derives its sample ticks from its own 16-bit phase accumulator, which adds the rate word every clock. A fixed-priority arbiter shares the single synchronous ROM read port, and channel A always wins a tie. Channel A's tick also leaves the block as a one-cycle strobe, so a neighbouring converter can sample at the same rate.

Top module: `dual_wave_player`

## Requirements
- R1: While reset is high and in the cycle after it, both levels are 0, both run flags are 0, and conv_strobe and rom_rd are 0.
- R2: A configuration write selects channel A when reg_addr[4] is 0 and channel B when it is 1. reg_addr[3:0] selects the byte: 0 control (bit0 run, bit1 loop, bit2 scale), 1 volume, 2/3/4 first address low/middle/high (high byte bits [2:0]), 5/6/7 last address low/middle/high, 8/9 rate word low/high. A write to address 0x1F loads the same control byte into both channels in one cycle. A write to one channel leaves the other channel's output unchanged.
- R3: Each channel adds its rate word to a 16-bit accumulator every clock and ticks on carry-out. conv_strobe is channel A's tick as a one-cycle pulse. A word of 1 gives one strobe every 65536 cycles, a word of 32768 gives one every 2 cycles, and a word of 0 gives none.
- R4: Writing a control byte with run set loads the current address from the first address and clears the accumulator. Successive ticks then output the bytes from the first address to the last address in ascending order, one per tick.
- R5: With loop clear, the run flag drops on the tick that outputs the byte at the last address. The level then holds that byte.
- R6: With loop set, the byte at the first address follows the byte at the last address, and the channel keeps running.
- R7: Writing a control byte with run clear stops the channel. No further bytes are output, and the level holds its value.
- R8: When both channels request a ROM read in the same cycle, channel A's address appears on the ROM port first and channel B's address appears in the next cycle. A request is held until it is granted.
- R9: rom_rd is a one-cycle pulse with rom_addr valid in the same cycle. The ROM returns the byte on rom_data in the following cycle.
- R10: With scale set, the level is the upper 8 bits of the unsigned product byte×volume. With scale clear, the level is the raw byte. The level follows a volume or control change one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Configuration byte write strobe |
| reg_addr | input | 5 | Configuration byte address |
| reg_wdata | input | 8 | Configuration byte data |
| rom_rd | output | 1 | ROM read strobe |
| rom_addr | output | ADDR_W | ROM read address |
| rom_data | input | DATA_W | ROM byte, valid one cycle after rom_rd |
| dac_a | output | DATA_W | Channel A output level |
| dac_b | output | DATA_W | Channel B output level |
| run_a | output | 1 | Channel A is playing |
| run_b | output | 1 | Channel B is playing |
| conv_strobe | output | 1 | Channel A sample tick for an external converter |

## Verification
Several properties are checked on every cycle: channel A's precedence at the arbiter, that channel B is granted only when it requests alone, the cleared state after reset, the absence of strobes while channel A's rate word is zero, and a stopped channel's level staying frozen when no configuration write arrives. Some behaviours are visible only from the bench's directed scenarios. These are the byte order inside a window, the wrap-around with looping, the one-shot stop, the exact strobe spacing for rate words 1 and 32768, the back-to-back ROM addresses when both channels start together, and the scaled output values.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int BUS_W  = 8;
  localparam int REG_AW = 5;
  localparam int OFF_W  = 4;

  localparam logic [OFF_W-1:0] OFF_CTRL = 4'd0;
  localparam logic [OFF_W-1:0] OFF_VOL  = 4'd1;
  localparam logic [OFF_W-1:0] OFF_FA0  = 4'd2;
  localparam logic [OFF_W-1:0] OFF_FA1  = 4'd3;
  localparam logic [OFF_W-1:0] OFF_FA2  = 4'd4;
  localparam logic [OFF_W-1:0] OFF_LA0  = 4'd5;
  localparam logic [OFF_W-1:0] OFF_LA1  = 4'd6;
  localparam logic [OFF_W-1:0] OFF_LA2  = 4'd7;
  localparam logic [OFF_W-1:0] OFF_RW0  = 4'd8;
  localparam logic [OFF_W-1:0] OFF_RW1  = 4'd9;

  localparam logic [REG_AW-1:0] JOINT_ADDR = 5'h1F;

  localparam int CTL_RUN   = 0;
  localparam int CTL_LOOP  = 1;
  localparam int CTL_SCALE = 2;
endpackage

// File: rtl/wp_rate_gen.sv
module wp_rate_gen #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [RATE_W-1:0] step,
  output logic              tick
);
  logic [RATE_W-1:0] phase_q;
  logic [RATE_W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
      tick    <= 1'b0;
    end else begin
      phase_q <= sum[RATE_W-1:0];
      tick    <= sum[RATE_W];
    end
  end
endmodule

// File: rtl/wp_rom_arb.sv
module wp_rom_arb #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 19
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        req,
  input  logic [NCH*ADDR_W-1:0] addr_flat,
  output logic [NCH-1:0]        gnt,
  output logic                  rom_rd,
  output logic [ADDR_W-1:0]     rom_addr,
  output logic [NCH-1:0]        ret_valid,
  output logic [ADDR_W-1:0]     ret_addr
);
  logic [ADDR_W-1:0] sel_addr;
  logic [NCH-1:0]    owner_q;

  // lowest index wins: scan downward so the last hit is the smallest index
  always_comb begin
    gnt      = '0;
    sel_addr = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt      = '0;
        gnt[i]   = 1'b1;
        sel_addr = addr_flat[i*ADDR_W +: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_rd    <= 1'b0;
      rom_addr  <= '0;
      owner_q   <= '0;
      ret_valid <= '0;
      ret_addr  <= '0;
    end else begin
      rom_rd    <= |gnt;
      owner_q   <= gnt;
      if (|gnt) rom_addr <= sel_addr;
      ret_valid <= rom_rd ? owner_q : '0;
      ret_addr  <= rom_addr;
    end
  end
endmodule

// File: rtl/wp_voice.sv
module wp_voice
  import wp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int RATE_W = 16,
  parameter int VOL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [OFF_W-1:0]  cfg_off,
  input  logic [BUS_W-1:0]  cfg_wdata,
  input  logic              gnt,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [DATA_W-1:0] ret_data,
  output logic              req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] level,
  output logic              running,
  output logic              tick,
  output logic [RATE_W-1:0] rate_word
);
  localparam int HI_W   = ADDR_W - 2 * BUS_W;
  localparam int RHI_W  = RATE_W - BUS_W;
  localparam int PROD_W = DATA_W + VOL_W;

  logic              loop_q, scale_q;
  logic [VOL_W-1:0]  vol_q;
  logic [ADDR_W-1:0] first_q, last_q, cur_q;
  logic [RATE_W-1:0] rate_q;
  logic              have_q, pend_q;
  logic [DATA_W-1:0] byte_q, raw_q;
  logic              ctrl_wr, start_evt;
  logic [PROD_W-1:0] prod;

  assign ctrl_wr   = cfg_we && (cfg_off == OFF_CTRL);
  assign start_evt = ctrl_wr && cfg_wdata[CTL_RUN];
  assign req       = running && !have_q && !pend_q;
  assign fetch_addr = cur_q;
  assign rate_word = rate_q;
  assign prod      = raw_q * vol_q;

  wp_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk    (clk),
    .rst    (rst),
    .restart(start_evt),
    .step   (rate_q),
    .tick   (tick)
  );

  // configuration bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      vol_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
      rate_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_off)
        OFF_VOL: vol_q <= cfg_wdata[VOL_W-1:0];
        OFF_FA0: first_q[BUS_W-1:0] <= cfg_wdata;
        OFF_FA1: first_q[2*BUS_W-1:BUS_W] <= cfg_wdata;
        OFF_FA2: first_q[ADDR_W-1:2*BUS_W] <= cfg_wdata[HI_W-1:0];
        OFF_LA0: last_q[BUS_W-1:0] <= cfg_wdata;
        OFF_LA1: last_q[2*BUS_W-1:BUS_W] <= cfg_wdata;
        OFF_LA2: last_q[ADDR_W-1:2*BUS_W] <= cfg_wdata[HI_W-1:0];
        OFF_RW0: rate_q[BUS_W-1:0] <= cfg_wdata;
        OFF_RW1: rate_q[RATE_W-1:BUS_W] <= cfg_wdata[RHI_W-1:0];
        default: ;
      endcase
    end
  end

  // outstanding ROM read tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
    end else if (gnt) begin
      pend_q <= 1'b1;
    end else if (ret_valid) begin
      pend_q <= 1'b0;
    end
  end

  // playback sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      loop_q  <= 1'b0;
      scale_q <= 1'b0;
      cur_q   <= '0;
      have_q  <= 1'b0;
      byte_q  <= '0;
      raw_q   <= '0;
    end else if (ctrl_wr) begin
      running <= cfg_wdata[CTL_RUN];
      loop_q  <= cfg_wdata[CTL_LOOP];
      scale_q <= cfg_wdata[CTL_SCALE];
      if (cfg_wdata[CTL_RUN]) begin
        cur_q  <= first_q;
        have_q <= 1'b0;
      end
    end else begin
      // a returned byte is kept only if it belongs to the current address
      if (ret_valid && running && !have_q && (ret_addr == cur_q)) begin
        have_q <= 1'b1;
        byte_q <= ret_data;
      end
      if (running && tick && have_q) begin
        raw_q  <= byte_q;
        have_q <= 1'b0;
        if (cur_q == last_q) begin
          if (loop_q) cur_q <= first_q;
          else        running <= 1'b0;
        end else begin
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

  // registered output level, optionally volume-scaled
  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else     level <= scale_q ? prod[PROD_W-1 -: DATA_W] : raw_q;
  end
endmodule

// File: rtl/dual_wave_player.sv
module dual_wave_player
  import wp_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int RATE_W = 16,
  parameter int VOL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              rom_rd,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              run_a,
  output logic              run_b,
  output logic              conv_strobe
);
  localparam int NCH = 2;

  logic                  joint;
  logic [NCH-1:0]        req_v, gnt_v, ret_v, run_v, tick_v;
  logic [NCH*ADDR_W-1:0] addr_flat;
  logic [ADDR_W-1:0]     ret_addr;
  logic [DATA_W-1:0]     level_v [NCH];
  logic [RATE_W-1:0]     rate_v  [NCH];
  logic [RATE_W-1:0]     rate_a;

  assign joint = (reg_addr == JOINT_ADDR);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic             we_c;
    logic [OFF_W-1:0] off_c;

    assign we_c  = reg_we && (joint || (reg_addr[REG_AW-1] == 1'(ch)));
    assign off_c = joint ? OFF_CTRL : reg_addr[OFF_W-1:0];

    wp_voice #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W), .VOL_W(VOL_W)
    ) u_voice (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (we_c),
      .cfg_off   (off_c),
      .cfg_wdata (reg_wdata),
      .gnt       (gnt_v[ch]),
      .ret_valid (ret_v[ch]),
      .ret_addr  (ret_addr),
      .ret_data  (rom_data),
      .req       (req_v[ch]),
      .fetch_addr(addr_flat[ch*ADDR_W +: ADDR_W]),
      .level     (level_v[ch]),
      .running   (run_v[ch]),
      .tick      (tick_v[ch]),
      .rate_word (rate_v[ch])
    );
  end

  wp_rom_arb #(.NCH(NCH), .ADDR_W(ADDR_W)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .req      (req_v),
    .addr_flat(addr_flat),
    .gnt      (gnt_v),
    .rom_rd   (rom_rd),
    .rom_addr (rom_addr),
    .ret_valid(ret_v),
    .ret_addr (ret_addr)
  );

  assign dac_a       = level_v[0];
  assign dac_b       = level_v[1];
  assign run_a       = run_v[0];
  assign run_b       = run_v[1];
  assign conv_strobe = tick_v[0];
  assign rate_a      = rate_v[0];
endmodule

// File: rtl/dual_wave_player_chk.sv
module dual_wave_player_chk #(
  parameter int DATA_W = 8,
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        req_v,
  input logic [1:0]        gnt_v,
  input logic              rom_rd,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              run_a,
  input logic              run_b,
  input logic              conv_strobe,
  input logic [RATE_W-1:0] rate_a
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (dac_a == '0 && dac_b == '0 && !run_a && !run_b && !conv_strobe && !rom_rd));

  // R8
  a_first_chk: assert property (@(posedge clk) disable iff (rst)
    req_v[0] |-> gnt_v[0]);

  // R8
  b_grant_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_v[1] |-> (req_v[1] && !req_v[0]));

  // R3
  zero_rate_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rate_a == '0) |-> !conv_strobe);

  // R5
  hold_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_a && $past(!run_a) && !reg_we && $past(!reg_we)) |=> $stable(dac_a));

  // R7
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_b && $past(!run_b) && !reg_we && $past(!reg_we)) |=> $stable(dac_b));
endmodule

bind dual_wave_player dual_wave_player_chk #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .req_v      (req_v),
  .gnt_v      (gnt_v),
  .rom_rd     (rom_rd),
  .dac_a      (dac_a),
  .dac_b      (dac_b),
  .run_a      (run_a),
  .run_b      (run_b),
  .conv_strobe(conv_strobe),
  .rate_a     (rate_a)
);

// File: tb/dual_wave_player_test.sv
`timescale 1ns/1ps
module dual_wave_player_test;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic          rom_rd;
  logic [AW-1:0] rom_addr;
  logic [7:0]    rom_data = '0;
  logic [7:0]    dac_a, dac_b;
  logic          run_a, run_b, conv_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_wave_player uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .dac_a(dac_a), .dac_b(dac_b), .run_a(run_a), .run_b(run_b), .conv_strobe(conv_strobe)
  );

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    return a[7:0] + 8'h40;
  endfunction

  // synchronous ROM model: byte available one cycle after the read strobe
  always @(posedge clk) if (rom_rd) rom_data <= rom_byte(rom_addr);

  // logs of level changes and ROM reads
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit clr = 0;
  logic [7:0]    seq_a [0:31];
  logic [7:0]    seq_b [0:31];
  logic [AW-1:0] rd_log [0:31];
  int            rd_cyc [0:31];
  int na = 0, nb = 0, nr = 0;
  logic [7:0] last_a = '0, last_b = '0;

  always @(negedge clk) begin
    if (clr) begin
      na = 0; nb = 0; nr = 0;
    end else if (!rst) begin
      if (dac_a != last_a) begin
        if (na < 32) seq_a[na] = dac_a;
        na++;
        last_a = dac_a;
      end
      if (dac_b != last_b) begin
        if (nb < 32) seq_b[nb] = dac_b;
        nb++;
        last_b = dac_b;
      end
      if (rom_rd) begin
        if (nr < 32) begin
          rd_log[nr] = rom_addr;
          rd_cyc[nr] = cyc;
        end
        nr++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_window(input logic [4:0] base, input logic [AW-1:0] f, input logic [AW-1:0] l);
    wr(base + 5'd2, f[7:0]);  wr(base + 5'd3, f[15:8]);  wr(base + 5'd4, {5'd0, f[18:16]});
    wr(base + 5'd5, l[7:0]);  wr(base + 5'd6, l[15:8]);  wr(base + 5'd7, {5'd0, l[18:16]});
  endtask

  task automatic clear_logs();
    @(posedge clk); clr = 1'b1;
    @(posedge clk); clr = 1'b0;
  endtask

  task automatic strobe_gap(output int gap);
    int n = 0;
    @(negedge clk);
    while (!conv_strobe && n < 70000) begin @(negedge clk); n++; end
    gap = 0;
    do begin @(negedge clk); gap++; end while (!conv_strobe && gap < 70000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dac_a == 8'h00 && dac_b == 8'h00, "R1 levels", {dac_a, dac_b}, 0);
    chk(!run_a && !run_b, "R1 run flags", {run_a, run_b}, 0);
    chk(!conv_strobe && !rom_rd, "R1 strobes", {conv_strobe, rom_rd}, 0);
  endtask

  task automatic t_rate();
    int gap;
    wr(5'h09, 8'h80);
    strobe_gap(gap);
    chk(gap == 2, "R3 word 32768", gap, 2);
    wr(5'h09, 8'h00);
    wr(5'h08, 8'h01);
    strobe_gap(gap);
    chk(gap == 65536, "R3 word 1", gap, 65536);
    wr(5'h08, 8'h00);
    wr(5'h09, 8'h10);
  endtask

  task automatic t_oneshot();
    set_window(5'h00, 19'h00010, 19'h00013);
    clear_logs();
    wr(5'h00, 8'h01);
    repeat (110) @(negedge clk);
    chk(na == 4, "R4 byte count", na, 4);
    for (int k = 0; k < 4; k++)
      chk(seq_a[k] == rom_byte(19'h10 + k), "R4 byte order", seq_a[k], rom_byte(19'h10 + k));
    chk(!run_a, "R5 run cleared", run_a, 0);
    repeat (40) @(negedge clk);
    chk(dac_a == rom_byte(19'h13) && na == 4, "R5 level held", dac_a, rom_byte(19'h13));
  endtask

  task automatic t_loop_stop();
    logic [7:0] held;
    int cnt;
    set_window(5'h00, 19'h00020, 19'h00022);
    clear_logs();
    wr(5'h00, 8'h03);
    repeat (125) @(negedge clk);
    chk(na >= 7, "R6 byte count", na, 7);
    for (int k = 0; k < 7; k++)
      chk(seq_a[k] == rom_byte(19'h20 + (k % 3)), "R6 wrap order", seq_a[k], rom_byte(19'h20 + (k % 3)));
    chk(run_a, "R6 still running", run_a, 1);
    wr(5'h00, 8'h02);
    @(negedge clk);
    chk(!run_a, "R7 run cleared", run_a, 0);
    held = dac_a;
    cnt = na;
    repeat (60) @(negedge clk);
    chk(dac_a == held && na == cnt, "R7 level frozen", dac_a, held);
  endtask

  task automatic t_chan_b();
    logic [7:0] a_before;
    a_before = dac_a;
    wr(5'h19, 8'h10);
    set_window(5'h10, 19'h7FFFE, 19'h7FFFF);
    clear_logs();
    wr(5'h10, 8'h01);
    repeat (60) @(negedge clk);
    chk(nb == 2, "R4 channel B count", nb, 2);
    chk(seq_b[0] == rom_byte(19'h7FFFE) && seq_b[1] == rom_byte(19'h7FFFF),
        "R4 channel B order", {seq_b[0], seq_b[1]}, {rom_byte(19'h7FFFE), rom_byte(19'h7FFFF)});
    chk(!run_b, "R5 channel B stop", run_b, 0);
    chk(dac_a == a_before && !run_a, "R2 channel A untouched", dac_a, a_before);
  endtask

  task automatic t_arb();
    set_window(5'h00, 19'h00030, 19'h00031);
    set_window(5'h10, 19'h00040, 19'h00041);
    clear_logs();
    wr(5'h1F, 8'h01);
    @(negedge clk);
    chk(run_a && run_b, "R2 joint start", {run_a, run_b}, 2'b11);
    repeat (60) @(negedge clk);
    chk(nr == 4, "R8 read count", nr, 4);
    chk(rd_log[0] == 19'h30 && rd_log[1] == 19'h40, "R8 first pair order",
        {rd_log[0][7:0], rd_log[1][7:0]}, 16'h3040);
    chk(rd_cyc[1] == rd_cyc[0] + 1, "R8 B served next cycle", rd_cyc[1] - rd_cyc[0], 1);
    chk(rd_log[2] == 19'h31 && rd_log[3] == 19'h41 && rd_cyc[3] == rd_cyc[2] + 1,
        "R9 second pair", {rd_log[2][7:0], rd_log[3][7:0]}, 16'h3141);
    chk(na == 2 && seq_a[0] == rom_byte(19'h30) && seq_a[1] == rom_byte(19'h31),
        "R8 channel A data", seq_a[1], rom_byte(19'h31));
    chk(nb == 2 && seq_b[0] == rom_byte(19'h40) && seq_b[1] == rom_byte(19'h41),
        "R8 channel B data", seq_b[1], rom_byte(19'h41));
  endtask

  task automatic t_volume();
    set_window(5'h00, 19'h00010, 19'h00010);
    wr(5'h01, 8'h80);
    wr(5'h00, 8'h05);
    repeat (40) @(negedge clk);
    chk(dac_a == 8'h28, "R10 half volume", dac_a, 8'h28);
    wr(5'h01, 8'h00);
    @(negedge clk);
    chk(dac_a == 8'h00, "R10 zero volume", dac_a, 8'h00);
    wr(5'h01, 8'hFF);
    @(negedge clk);
    chk(dac_a == 8'h4F, "R10 full volume", dac_a, 8'h4F);
    wr(5'h00, 8'h00);
    @(negedge clk);
    chk(dac_a == 8'h50, "R10 scale off", dac_a, 8'h50);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_rate();
    t_oneshot();
    t_loop_stop();
    t_chan_b();
    t_arb();
    t_volume();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule